// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Write Unlock

This block is a serial slave on a two-wire bus (I2C signalling: a clock line and an open-drain data line). It gives a bus master access to a small bank of clock/control registers and to one status register. Both bus lines are brought into the system clock domain and filtered into start, stop, rising-edge and falling-edge events. A transfer opens with an address byte that carries a device identifier, select bits and a read/write flag. A write then sends a two-byte register address followed by data bytes. A read streams bytes from the current pointer.

Register-bank writes are locked by default. The master unlocks them by writing 02h and then 06h to the status register, in two separate transfers. Accepted data is staged and is not committed at once. After the stop that ends a write, an internal write cycle runs for a fixed number of system clocks. During that cycle the slave ignores the bus and keeps its data line released. The staged bytes reach the register bank when the cycle ends.

Top module: `i2c_rf_slave`

## Requirements
- R1: After a start, the first byte's upper seven bits must equal {DEV_ID, SEL_BITS}, with the device identifier in the upper four bits and the select bits in the lower three. On a match the slave drives an acknowledge (SDA low) in the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start. Bit 0 of that byte selects a read (1) or a write (0).
- R2: In a write transfer, both register-address bytes (high byte first) are always acknowledged. Each data byte that is accepted is also acknowledged in its ninth clock.
- R3: While the bank is locked, no data byte sent to a bank address is acknowledged, and no such byte is stored.
- R4: The status register sits at address 003Fh. A write to it accepts exactly one data byte. A second data byte in the same transfer gets no acknowledge and has no effect.
- R5: The committed status byte is 02h after a write of 02h. It becomes 06h only when 06h is written while it already reads 02h or 06h. Any other written value clears it to 00h. Bank writes are accepted only while it reads 06h. Status bit 1 is the first unlock stage and bit 2 is the second; all other bits read 0.
- R6: A bank write accepts at most 8 data bytes. Byte k of the transfer goes to the address whose low 3 bits are (start address + k) mod 8 and whose other bits are those of the start address. A 9th byte gets no acknowledge and is not stored. Bank index = address bits [REG_AW-1:0].
- R7: A read sends the byte at the pointer, MSB first, and then advances the pointer by one, except at 003Fh, where it stays. A master acknowledge starts the next byte. A master no-acknowledge ends the transmission with SDA released. A write transfer sets the pointer to its register address.
- R8: A stop that ends a write with at least one accepted byte starts a busy period of BUSY_CYC clocks. During it the slave acknowledges nothing and keeps SDA released. The staged bytes become readable when the period ends.
- R9: A start seen in any state, including a repeated start, aborts the current transfer and discards uncommitted staged bytes. A stop returns the slave to idle.
- R10: After reset, SDA is released, every bank register reads 00h and the status register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
The busy window is the hardest state to observe from the ports, because it shows itself only as silence. The stimulus therefore issues a new start and address byte straight after the stop that ends a write, while the cycle is still running, and expects no acknowledge. It then waits out the cycle and reads the data back. The unlock sequence spans several transfers, each with its own write cycle. The bench walks through it in order, including a wrong first step and a double-byte status write. Random page writes then start at assorted offsets within a page, so that the address wrap and the 9-byte cap are both exercised.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int PAGE_W = 3;
  localparam int PAGE_N = 1 << PAGE_W;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} bus_st_e;

  // offset inside a page, wrapping at the page boundary
  function automatic logic [PAGE_W-1:0] page_off(logic [PAGE_W-1:0] b, int unsigned k);
    return b + PAGE_W'(k);
  endfunction

  // two-stage unlock: bit0 = first stage, bit1 = second stage
  function automatic logic [1:0] unlock_next(logic [1:0] cur, logic [7:0] v);
    if (v == 8'h02) return 2'b01;
    if (v == 8'h06 && cur[0]) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [15:0] ptr_next(logic [15:0] p, logic [15:0] stat);
    return (p == stat) ? p : p + 16'd1;
  endfunction

  function automatic logic dev_match(logic [6:0] b, logic [3:0] id, logic [2:0] sel);
    return b == {id, sel};
  endfunction
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int W = STAGES + 1;
  logic [W-1:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[W-2:0], scl_i};
      sda_p <= {sda_p[W-2:0], sda_i};
    end

  logic scl_s, scl_d, sda_d;
  assign scl_s     = scl_p[W-2];
  assign scl_d     = scl_p[W-1];
  assign sda_s     = sda_p[W-2];
  assign sda_d     = sda_p[W-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rf_wcycle.sv
module i2c_rf_wcycle #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end

  assert_cycle_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy);
  assert_cycle_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank
  import i2c_rf_pkg::*;
#(
  parameter int          AW        = 5,
  parameter logic [15:0] STAT_ADDR = 16'h003F
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic                        stage_stat,
  input  logic [PAGE_W:0]             stage_n,
  input  logic [PAGE_N-1:0][7:0]      stage,
  input  logic [AW-1:0]               base_idx,
  input  logic [15:0]                 rd_addr,
  output logic [7:0]                  rd_data,
  output logic                        wel_ok
);
  localparam int DEPTH = 1 << AW;
  logic [7:0]    mem [DEPTH];
  logic [1:0]    lk;
  logic [AW-1:0] slot [PAGE_N];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    assign slot[g] = {base_idx[AW-1:PAGE_W], page_off(base_idx[PAGE_W-1:0], g)};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lk <= 2'b00;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      if (stage_stat) lk <= unlock_next(lk, stage[0]);
      else
        for (int i = 0; i < PAGE_N; i++)
          if ((PAGE_W+1)'(i) < stage_n) mem[slot[i]] <= stage[i];
    end

  assign rd_data = (rd_addr == STAT_ADDR) ? {5'b0, lk, 1'b0} : mem[rd_addr[AW-1:0]];
  assign wel_ok  = &lk;

  // R5: the unlocked state is never reached straight from the cleared state
  assert_unlock_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && stage_stat && lk == 2'b00) |=> lk != 2'b11);
endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [3:0]  DEV_ID    = 4'b1101,
  parameter logic [2:0]  SEL_BITS  = 3'b111,
  parameter int          REG_AW    = 5,
  parameter logic [15:0] STAT_ADDR = 16'h003F,
  parameter int          BUSY_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wc_busy, wc_done, launch, wel_ok;
  logic [7:0] rd_data;

  bus_st_e st, nxt_st, dec_next;
  logic [3:0]             cnt;
  logic                   in_ack, mack, oe, dec_ack, stage_stat;
  logic [7:0]             shreg, txreg, addr_hi;
  logic [15:0]            wr_addr, ptr;
  logic [PAGE_N-1:0][7:0] stage;
  logic [PAGE_W:0]        stage_n;

  i2c_rf_sync #(.STAGES(2)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s, .scl_rise, .scl_fall, .bus_start, .bus_stop);

  assign launch = bus_stop && !wc_busy && stage_n != '0;

  i2c_rf_wcycle #(.CYC(BUSY_CYC)) u_wc (
    .clk, .rst_n, .launch, .busy(wc_busy), .done(wc_done));

  i2c_rf_bank #(.AW(REG_AW), .STAT_ADDR(STAT_ADDR)) u_bank (
    .clk, .rst_n, .commit(wc_done), .stage_stat, .stage_n, .stage,
    .base_idx(wr_addr[REG_AW-1:0]), .rd_addr(ptr), .rd_data, .wel_ok);

  // named events for the checks
  logic rx_state, rx_done, dev_miss_evt, lock_drop_evt, addr_byte_evt;
  assign rx_state      = st inside {S_DEV, S_AHI, S_ALO, S_WR};
  assign rx_done       = !wc_busy && scl_fall && rx_state && !in_ack && cnt == 4'd8;
  assign dev_miss_evt  = rx_done && st == S_DEV && !dec_ack;
  assign lock_drop_evt = rx_done && st == S_WR && wr_addr != STAT_ADDR && !wel_ok;
  assign addr_byte_evt = rx_done && (st == S_AHI || st == S_ALO);

  // ack decision at the end of a received byte
  always_comb begin
    dec_ack  = 1'b1;
    dec_next = S_IDLE;
    case (st)
      S_DEV: begin
        dec_ack  = dev_match(shreg[7:1], DEV_ID, SEL_BITS);
        dec_next = shreg[0] ? S_RD : S_AHI;
      end
      S_AHI: dec_next = S_ALO;
      S_ALO: dec_next = S_WR;
      S_WR: begin
        dec_ack  = (wr_addr == STAT_ADDR) ? (stage_n == '0)
                                          : (wel_ok && stage_n < (PAGE_W+1)'(PAGE_N));
        dec_next = S_WR;
      end
      default: dec_ack = 1'b0;
    endcase
    if (!dec_ack) dec_next = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt_st <= S_IDLE; cnt <= '0; in_ack <= 1'b0; mack <= 1'b0;
      oe <= 1'b0; shreg <= '0; txreg <= '0; addr_hi <= '0; wr_addr <= '0;
      ptr <= '0; stage <= '0; stage_n <= '0; stage_stat <= 1'b0;
    end else if (wc_busy) begin
      if (wc_done) begin
        stage_n    <= '0;
        stage_stat <= 1'b0;
      end
    end else if (bus_start) begin
      st <= S_DEV; cnt <= '0; in_ack <= 1'b0; oe <= 1'b0;
      stage_n <= '0; stage_stat <= 1'b0;
    end else if (bus_stop) begin
      st <= S_IDLE; cnt <= '0; in_ack <= 1'b0; oe <= 1'b0;
    end else if (st != S_IDLE && scl_rise) begin
      if (st == S_RD) begin
        if (in_ack) mack <= ~sda_s;
        else        cnt  <= cnt + 4'd1;
      end else if (!in_ack) begin
        shreg <= {shreg[6:0], sda_s};
        cnt   <= cnt + 4'd1;
      end
    end else if (st != S_IDLE && scl_fall) begin
      if (st == S_RD) begin
        if (!in_ack) begin
          if (cnt == 4'd8) begin
            oe     <= 1'b0;
            in_ack <= 1'b1;
          end else oe <= ~txreg[3'd7 - cnt[2:0]];
        end else begin
          in_ack <= 1'b0;
          cnt    <= '0;
          if (mack) begin
            txreg <= rd_data;
            oe    <= ~rd_data[7];
            ptr   <= ptr_next(ptr, STAT_ADDR);
          end else begin
            st <= S_IDLE;
            oe <= 1'b0;
          end
        end
      end else if (!in_ack) begin
        if (cnt == 4'd8) begin
          in_ack <= 1'b1;
          oe     <= dec_ack;
          nxt_st <= dec_next;
          case (st)
            S_AHI: addr_hi <= shreg;
            S_ALO: begin
              wr_addr <= {addr_hi, shreg};
              ptr     <= {addr_hi, shreg};
            end
            S_WR: if (dec_ack) begin
              if (wr_addr == STAT_ADDR) begin
                stage[0]   <= shreg;
                stage_stat <= 1'b1;
                stage_n    <= (PAGE_W+1)'(1);
              end else begin
                stage[stage_n[PAGE_W-1:0]] <= shreg;
                stage_n <= stage_n + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else begin
        in_ack <= 1'b0;
        cnt    <= '0;
        st     <= nxt_st;
        if (nxt_st == S_RD) begin
          txreg <= rd_data;
          oe    <= ~rd_data[7];
          ptr   <= ptr_next(ptr, STAT_ADDR);
        end else oe <= 1'b0;
      end
    end

  assign sda_oe = oe;

  assert_addr_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss_evt |=> !sda_oe);
  assert_addr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_byte_evt |=> sda_oe);
  assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop_evt |=> (stage_n == $past(stage_n)) && !sda_oe);
  assert_stat_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_stat |-> stage_n == (PAGE_W+1)'(1));
  assert_page_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_n <= (PAGE_W+1)'(PAGE_N));
  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wc_busy |-> !sda_oe);
  assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !wc_busy) |=> (st == S_DEV && !sda_oe && stage_n == '0));
endmodule

// File: tb/sim_i2c_rf_slave.sv
module sim_i2c_rf_slave;
  localparam int Q    = 5;
  localparam int BUSY = 300;
  localparam logic [3:0] ID  = 4'b1101;
  localparam logic [2:0] SEL = 3'b111;
  localparam logic [15:0] STAT = 16'h003F;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_rf_slave #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  int n_cmp = 0, n_mis = 0;
  logic [7:0] mreg [32];
  logic [1:0] mstat;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic       dack [16];
  logic       dev_ack, ah_ack, al_ack;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------- bench-side model ----------
  function automatic logic [7:0] m_read(logic [15:0] a);
    return (a == STAT) ? {5'b0, mstat, 1'b0} : mreg[a[4:0]];
  endfunction
  function automatic logic [15:0] m_next(logic [15:0] a);
    return (a == STAT) ? a : a + 16'd1;
  endfunction
  function automatic logic [4:0] m_slot(logic [15:0] a, int k);
    logic [2:0] o;
    o = a[2:0] + 3'(k);
    return {a[4:3], o};
  endfunction
  function automatic logic m_dack(logic [15:0] a, int k);
    if (a == STAT) return k == 0;
    return (mstat == 2'b11) && k < 8;
  endfunction
  function automatic logic [1:0] m_unlock(logic [1:0] c, logic [7:0] v);
    if (v == 8'h02) return 2'b01;
    if (v == 8'h06 && (c == 2'b01 || c == 2'b11)) return 2'b11;
    return 2'b00;
  endfunction
  task automatic m_apply(input logic [15:0] a, input int n);
    if (n == 0) return;
    if (a == STAT) mstat = m_unlock(mstat, wbuf[0]);
    else if (mstat == 2'b11)
      for (int k = 0; k < n && k < 8; k++) mreg[m_slot(a, k)] = wbuf[k];
  endtask

  // ---------- bus primitives ----------
  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bit_out(input logic b);
    sda_m = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); b = sda_bus; w(Q); scl = 1'b0; w(Q);
  endtask
  task automatic bstart;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl = 1'b0; w(Q);
  endtask
  task automatic bstop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
  endtask
  task automatic wb(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask
  task automatic rb(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~give_ack);
  endtask
  task automatic settle; w(BUSY + 60); endtask

  // write transfer: start, device, address, n data bytes from wbuf, optional stop
  task automatic do_write(input logic [15:0] a, input int n, input logic stop_it);
    bstart;
    wb({ID, SEL, 1'b0}, dev_ack);
    wb(a[15:8], ah_ack);
    wb(a[7:0], al_ack);
    for (int k = 0; k < n; k++) wb(wbuf[k], dack[k]);
    if (stop_it) bstop;
  endtask
  // read n bytes from the current pointer (optionally after setting it)
  task automatic do_read(input logic set_ptr, input logic [15:0] a, input int n);
    logic x;
    if (set_ptr) begin
      bstart; wb({ID, SEL, 1'b0}, x); wb(a[15:8], x); wb(a[7:0], x);
    end
    bstart;
    wb({ID, SEL, 1'b1}, dev_ack);
    for (int k = 0; k < n; k++) rb(k != n - 1, rbuf[k]);
    bstop;
  endtask
  task automatic full_write(input string tag, input logic [15:0] a, input int n);
    do_write(a, n, 1'b1);
    chk({tag, " dev ack"}, dev_ack, 1);
    chk({tag, " addr acks"}, {ah_ack, al_ack}, 2'b11);
    for (int k = 0; k < n; k++) chk($sformatf("%s data ack %0d", tag, k), dack[k], m_dack(a, k));
    m_apply(a, n);
    settle;
  endtask
  task automatic check_read(input string tag, input logic [15:0] a, input int n);
    logic [15:0] p;
    do_read(1'b1, a, n);
    p = a;
    for (int k = 0; k < n; k++) begin
      chk($sformatf("%s byte %0d @%0h", tag, k, p), rbuf[k], m_read(p));
      p = m_next(p);
    end
  endtask

  initial begin
    logic ack;
    logic [15:0] a;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    mstat = 2'b00;
    w(4); rst_n = 1'b1; w(4);

    // R10: reset state
    chk("R10 sda released", sda_oe, 0);
    check_read("R10 status", STAT, 1);
    check_read("R10 bank", 16'h0000, 4);

    // R1: identifier and select mismatch, then a match
    bstart; wb({4'b1100, SEL, 1'b0}, ack); bstop; chk("R1 bad id nack", ack, 0);
    bstart; wb({ID, 3'b110, 1'b0}, ack); bstop; chk("R1 bad select nack", ack, 0);
    bstart; wb({ID, SEL, 1'b0}, ack); bstop; chk("R1 match ack", ack, 1);

    // R2/R3: locked bank write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    full_write("R3 locked", 16'h0004, 3);
    check_read("R3 not stored", 16'h0004, 3);

    // R5: 06h without 02h first clears, bank stays locked
    wbuf[0] = 8'h06; full_write("R5 06 first", STAT, 1);
    check_read("R5 status after 06", STAT, 1);
    wbuf[0] = 8'h02; full_write("R5 step 02", STAT, 1);
    check_read("R5 status after 02", STAT, 1);
    wbuf[0] = 8'h5A; full_write("R5 half unlocked", 16'h0002, 1);
    check_read("R5 half unlocked no store", 16'h0002, 1);
    wbuf[0] = 8'h06; full_write("R5 step 06", STAT, 1);
    check_read("R5 status after 06", STAT, 1);

    // R4: second status byte refused
    wbuf[0] = 8'h06; wbuf[1] = 8'h55; full_write("R4 two bytes", STAT, 2);
    check_read("R4 status kept", STAT, 1);

    // R6: page wrap from offset 5 and 9th byte refused
    for (int k = 0; k < 9; k++) wbuf[k] = 8'hA0 + 8'(k);
    full_write("R6 page", 16'h000D, 9);
    check_read("R6 page readback", 16'h0008, 8);
    check_read("R6 next page untouched", 16'h0010, 1);

    // R8: address during busy window is refused, data arrives after
    wbuf[0] = 8'hC3; do_write(16'h0014, 1, 1'b1); m_apply(16'h0014, 1);
    bstart; wb({ID, SEL, 1'b0}, ack); bstop; chk("R8 busy nack", ack, 0);
    settle;
    check_read("R8 committed", 16'h0014, 1);

    // R9: repeated start discards staged byte
    wbuf[0] = 8'hEE; do_write(16'h0008, 1, 1'b0);
    chk("R9 staged byte ack", dack[0], 1);
    do_read(1'b0, 16'h0008, 1);
    chk("R9 read after abort", rbuf[0], m_read(16'h0008));
    settle;
    check_read("R9 still old", 16'h0008, 1);

    // R7: pointer advance, stays on status, continues after nack
    check_read("R7 into status", 16'h003E, 3);
    check_read("R7 run", 16'h000A, 3);
    do_read(1'b0, 16'h0000, 1);
    chk("R7 pointer after nack", rbuf[0], m_read(16'h000D));

    // random page writes and reads (R2 R6 R7)
    for (int it = 0; it < 14; it++) begin
      a = {11'($urandom_range(0, 3)), 5'($urandom_range(0, 31))};
      if (a == STAT) a = 16'h0001;
      n = $urandom_range(1, 9);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      full_write("R6 random", a, n);
      check_read("R7 random", {a[15:3], 3'b000}, $urandom_range(1, 8));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule